// File: doc/BRIEF.md
# I2C Target Address Phase Matcher

This block sits behind the pads of an I2C target. It samples SCL and SDA with the system clock and follows the bus through START and STOP conditions. It shifts in the address byte, or the two address bytes in 10-bit mode, and compares them with a programmable own address. It drives the acknowledge bit low through an open-drain pull-down enable.

When the whole address matches, it raises a one-cycle match strobe and reports the transfer direction. Once the address phase is over, it waits for the next START or STOP. Data bytes, clock stretching and arbitration are handled elsewhere.

The own address comes in on a 10-bit input. A mode input selects between the 7-bit and 10-bit forms. Both the mode input and the own address must be held stable while the bus is busy.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, match_o, rnw_o, busy_o and sda_pull_o are all low.
- R2: busy_o goes high after a START condition, which is SDA falling while SCL is high. It goes low after a STOP condition, which is SDA rising while SCL is high. It does not change otherwise.
- R3: With ten_bit_i=0, the first byte after START is taken MSB first. The target acknowledges by pulling SDA low during the ninth SCL clock when byte bits 7:1 equal own_addr_i[6:0]. It releases SDA after that clock.
- R4: Byte bit 0 of the first address byte is the direction: 0 for a controller write, 1 for a controller read. rnw_o carries it whenever match_o pulses.
- R5: A first byte that does not match gets no acknowledge and no match. All further bits up to the next START or STOP are ignored, so SDA stays released.
- R6: With ten_bit_i=1, a first byte whose bits 7:3 are 11110 and whose bits 2:1 equal own_addr_i[9:8] is acknowledged. match_o does not pulse for this byte.
- R7: With ten_bit_i=1, after an acknowledged first byte, a second byte equal to own_addr_i[7:0] is acknowledged and match_o pulses. Any other second byte gets no acknowledge and no match.
- R8: A START at any point restarts address reception from the first bit. A STOP returns the block to idle. Both release SDA.
- R9: match_o is a single-cycle pulse, raised together with the acknowledge pull-down of the last address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| own_addr_i | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| match_o | output | 1 | One-cycle strobe when the full address matches |
| rnw_o | output | 1 | Direction bit of the matched transfer, 1 means read |
| busy_o | output | 1 | Bus held between a START and a STOP |
| sda_pull_o | output | 1 | Open-drain enable that pulls SDA low |

## Verification
The hardest case to reach is a repeated START that arrives partway through an address byte. It must throw away the partial shift register and bit count without a STOP in between. The bench reaches it by sending four bits and then, while SCL is low, raising SDA. It then lifts SCL and drops SDA. A complete read address follows, and this address must match with the correct direction.

The bench also reaches the 10-bit case where the first byte is acknowledged but the second is not. This separates the acknowledge of the first byte from the match strobe.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam logic [4:0] TEN_MARK = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ACK1,
    ST_ADDR2,
    ST_ACK2,
    ST_IGNORE
  } am_state_e;
endpackage

// File: rtl/i2c_sync_2ff.sv
module i2c_sync_2ff #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;  // idle bus reads high
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SDA edges with SCL held high are bus conditions, never data
  assign start_o    = scl_q & scl_s_i &  sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q &  sda_s_i;
  assign scl_rise_o = ~scl_q &  scl_s_i;
  assign scl_fall_o =  scl_q & ~scl_s_i;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  output logic              hit_first_o,
  output logic              hit_second_o
);
  logic hit7, hit10;

  assign hit7  = ~ten_bit_i & (byte_i[7:1] == own_addr_i[6:0]);
  assign hit10 =  ten_bit_i & (byte_i[7:3] == TEN_MARK)
                            & (byte_i[2:1] == own_addr_i[9:8]);

  assign hit_first_o  = hit7 | hit10;
  assign hit_second_o = ten_bit_i & (byte_i == own_addr_i[7:0]);
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  output logic              match_o,
  output logic              rnw_o,
  output logic              busy_o,
  output logic              sda_pull_o
);
  localparam int BITS  = 8;
  localparam int CNT_W = $clog2(BITS + 1);

  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic hit_first, hit_second;

  am_state_e        state_q;
  logic [BITS-1:0]  shreg_q;
  logic [CNT_W-1:0] bitcnt_q;
  logic             byte_done;

  i2c_sync_2ff #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2c_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i      (shreg_q),
    .own_addr_i  (own_addr_i),
    .ten_bit_i   (ten_bit_i),
    .hit_first_o (hit_first),
    .hit_second_o(hit_second)
  );

  // eighth bit sampled and SCL now low: decide the acknowledge
  assign byte_done = scl_fall & (bitcnt_q == CNT_W'(BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
    end else if (stop_det) begin
      busy_o <= 1'b0;
    end else if (start_det) begin
      busy_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '0;
      bitcnt_q   <= '0;
      sda_pull_o <= 1'b0;
      match_o    <= 1'b0;
      rnw_o      <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_det) begin
        state_q    <= ST_ADDR1;
        bitcnt_q   <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR1, ST_ADDR2: begin
            if (scl_rise && bitcnt_q < CNT_W'(BITS)) begin
              shreg_q  <= {shreg_q[BITS-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (byte_done) begin
              if (state_q == ST_ADDR1) begin
                if (hit_first) begin
                  state_q    <= ST_ACK1;
                  sda_pull_o <= 1'b1;
                  rnw_o      <= shreg_q[0];
                  match_o    <= ~ten_bit_i;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else begin
                if (hit_second) begin
                  state_q    <= ST_ACK2;
                  sda_pull_o <= 1'b1;
                  match_o    <= 1'b1;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end
            end
          end
          ST_ACK1: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bitcnt_q   <= '0;
              state_q    <= ten_bit_i ? ST_ADDR2 : ST_IGNORE;
            end
          end
          ST_ACK2: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              state_q    <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic match_o,
  input logic busy_o,
  input logic sda_pull_o
);
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det && !stop_det |=> busy_o); // R2
  AST_BUSY_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o); // R2
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o); // R8
  AST_IDLE_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sda_pull_o); // R8
  AST_MATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o); // R9
  AST_MATCH_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> sda_pull_o && busy_o); // R9
endmodule

bind i2c_addr_matcher i2c_am_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .match_o   (match_o),
  .busy_o    (busy_o),
  .sda_pull_o(sda_pull_o)
);

// File: tb/sim_i2c_addr_matcher.sv
`timescale 1ns/1ps
module sim_i2c_addr_matcher;
  localparam int Q = 16;  // clocks per SCL half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic [9:0] own = 10'h2A5;
  logic       ten = 1'b0;
  logic       match, rnw, busy, pull;
  logic       sda_line;

  int nvec = 0;
  int nerr = 0;
  bit exp_q[$];
  logic match_d = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = sda_drv & ~pull;  // wired-AND open drain

  i2c_addr_matcher u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .own_addr_i(own),
    .ten_bit_i (ten),
    .match_o   (match),
    .rnw_o     (rnw),
    .busy_o    (busy),
    .sda_pull_o(pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected direction on each match strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (match && match_d) chk(1'b0, "R9 pulse width", 2, 1);
      if (match) begin
        if (exp_q.size() == 0) chk(1'b0, "R5/R6/R7 unexpected match", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          chk(rnw == e, "R4 direction", rnw, e);
        end
      end
    end
    match_d <= match;
  end

  task automatic i2c_start();
    wt(Q/2); sda_drv = 1'b1; wt(Q/2);
    scl = 1'b1; wt(Q);
    sda_drv = 1'b0; wt(Q);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    wt(Q/2); sda_drv = 1'b0; wt(Q/2);
    scl = 1'b1; wt(Q);
    sda_drv = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input bit b);
    wt(Q/2); sda_drv = b; wt(Q/2);
    scl = 1'b1; wt(Q);
    scl = 1'b0;
  endtask

  task automatic send_byte_ack(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wt(Q/2); sda_drv = 1'b1; wt(Q/2);
    scl = 1'b1; wt(Q/2);
    a = ~sda_line;
    chk(a == exp_ack, req, a, exp_ack);
    wt(Q/2); scl = 1'b0;
    wt(Q/2);
    chk(!pull, "R3 release after ack", pull, 0);
  endtask

  task automatic end_txn(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    wt(5);
    chk(!match && !rnw && !busy && !pull, "R1 reset state",
        {match, rnw, busy, pull}, 0);
    rst_n = 1'b1;
    wt(10);

    // 7-bit write, own[6:0]=0x25
    i2c_start(); wt(4);
    chk(busy, "R2 busy after start", busy, 1);
    exp_q.push_back(1'b0);
    send_byte_ack({7'h25, 1'b0}, 1'b1, "R3 7-bit write ack");
    i2c_stop(); wt(4);
    chk(!busy && !pull, "R2 busy cleared by stop", busy, 0);
    end_txn("R3 missing match");

    // 7-bit read
    i2c_start();
    exp_q.push_back(1'b1);
    send_byte_ack({7'h25, 1'b1}, 1'b1, "R4 7-bit read ack");
    i2c_stop(); end_txn("R4 missing match");

    // mismatch, then a would-be match byte ignored
    i2c_start();
    send_byte_ack({7'h26, 1'b0}, 1'b0, "R5 mismatch no ack");
    send_byte_ack({7'h25, 1'b0}, 1'b0, "R5 later bits ignored");
    i2c_stop(); end_txn("R5");

    // 10-bit full match, own=0x2A5
    ten = 1'b1;
    i2c_start();
    send_byte_ack({5'b11110, 2'b10, 1'b0}, 1'b1, "R6 first byte ack");
    chk(exp_q.size() == 0, "R6 no early match", 0, 0);
    exp_q.push_back(1'b0);
    send_byte_ack(8'hA5, 1'b1, "R7 second byte ack");
    i2c_stop(); end_txn("R7 missing match");

    // 10-bit read direction from first byte
    i2c_start();
    send_byte_ack({5'b11110, 2'b10, 1'b1}, 1'b1, "R6 first byte ack read");
    exp_q.push_back(1'b1);
    send_byte_ack(8'hA5, 1'b1, "R7 second byte ack read");
    i2c_stop(); end_txn("R7 missing match read");

    // 10-bit second byte mismatch
    i2c_start();
    send_byte_ack({5'b11110, 2'b10, 1'b0}, 1'b1, "R6 first byte ack");
    send_byte_ack(8'hA4, 1'b0, "R7 second mismatch no ack");
    i2c_stop(); end_txn("R7");

    // 10-bit wrong upper bits
    i2c_start();
    send_byte_ack({5'b11110, 2'b01, 1'b0}, 1'b0, "R6 upper bits mismatch");
    i2c_stop(); end_txn("R6");

    // 10-bit mode with a 7-bit style byte
    i2c_start();
    send_byte_ack({7'h25, 1'b0}, 1'b0, "R6 marker required");
    i2c_stop(); end_txn("R6 marker");

    // repeated start mid-byte
    ten = 1'b0;
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_start(); wt(4);
    chk(busy && !pull, "R8 restart state", {busy, pull}, 2);
    exp_q.push_back(1'b1);
    send_byte_ack({7'h25, 1'b1}, 1'b1, "R8 match after restart");
    i2c_stop(); wt(4);
    chk(!busy && !pull, "R8 stop to idle", {busy, pull}, 0);
    end_txn("R8 missing match");

    wt(20);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule